// File: doc/BRIEF.md
# Deferred-Update System Clock Prescaler

This block holds an 8-bit system clock control register and turns one of two oscillator tick streams into a clock-enable pulse for the core. Software can write a divide setting for the main oscillator, which is used in active and sleep modes. It can also write a divide setting for the watch oscillator, which is used in subactive and subsleep modes. A written setting does not change the clock at once. The settings are armed only when the sleep strobe fires. Each prescaler then starts using its armed ratio at the end of the period already under way, so the output never shows a clipped or stretched period at the change.

The main oscillator and the watch oscillator each arrive as a tick enable in the system clock domain. Each tick stream drives its own free-running prescaler. A mode input chooses which prescaler feeds the output. A change of that input is acted on only when the prescaler currently in use completes a period. The three upper register bits are stored and passed out unchanged, for an external power-mode controller to decode.

Top module: `sysclk_div_ctl`

## Requirements
- R1: After reset the register reads 0x00, the flag outputs are 000, and in active mode every main tick produces a clock-enable pulse.
- R2: A write stores all 8 bits. The next cycle the read port returns the written byte, and flags_o carries bits 7:5 of it.
- R3: The active divide field is bits 4:2. With bit 4 at 0 the main ratio is 1 whatever bits 3:2 hold; 100 gives 8, 101 gives 16, 110 gives 32 and 111 gives 64 main ticks per pulse.
- R4: The subactive divide field is bits 1:0. 00 gives 8, 01 gives 4, and 10 or 11 give 2 watch ticks per pulse.
- R5: A write with no sleep strobe leaves the pulse rate unchanged, while the read port shows the new value.
- R6: A sleep strobe arms both divide fields. The running period completes at its old length, and the new ratio applies from the following period.
- R7: With sub_mode_i low the output follows the main prescaler; with it high, the watch prescaler. A change of sub_mode_i takes effect at the next pulse of the path in use, and that pulse is still issued.
- R8: clk_en_o rises for one cycle, in the cycle after the tick that ends a period. No tick on the path in use means no pulse.
- R9: When a write and a sleep strobe fall in the same cycle, the sleep arms the register contents as they stood before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register contents |
| main_tick | input | 1 | Main oscillator tick enable |
| watch_tick | input | 1 | Watch oscillator tick enable |
| sub_mode_i | input | 1 | 0 selects the active path, 1 the subactive path |
| sleep_i | input | 1 | Sleep-instruction strobe |
| flags_o | output | 3 | Stored mode-selection bits 7:5 |
| clk_en_o | output | 1 | Clock-enable pulse |

## Verification
The assertions assume that every input is synchronous to clk and is sampled at the rising edge. They also assume that a tick stream is a plain level sampled once per edge, so a tick that stays high for several cycles counts once per cycle. The stimulus changes inputs only on falling edges. It holds both tick streams high, so a period in cycles equals the ratio. It keeps the selected path ticking whenever a mode change is pending, so that change always reaches a pulse boundary.

// File: rtl/sysclk_div_pkg.sv
package sysclk_div_pkg;
  localparam int REG_W   = 8;
  localparam int FLAG_W  = 3;
  localparam int ACT_W   = 3;
  localparam int SUB_W   = 2;
  localparam int SHIFT_W = 3;
  localparam int CNT_W   = 6;

  localparam int FLAG_LSB = ACT_W + SUB_W;
  localparam int ACT_LSB  = SUB_W;

  localparam logic [SHIFT_W-1:0] MAIN_RST_SHIFT = 3'd0;
  localparam logic [SHIFT_W-1:0] SUB_RST_SHIFT  = 3'd3;

  // active field: top bit clear -> undivided, else 8 << low bits
  function automatic logic [SHIFT_W-1:0] act_shift(input logic [ACT_W-1:0] f);
    if (!f[ACT_W-1]) return '0;
    return SHIFT_W'(3) + SHIFT_W'(f[ACT_W-2:0]);
  endfunction

  // subactive field: 1x -> /2, 01 -> /4, 00 -> /8
  function automatic logic [SHIFT_W-1:0] sub_shift(input logic [SUB_W-1:0] f);
    if (f[1]) return SHIFT_W'(1);
    if (f[0]) return SHIFT_W'(2);
    return SHIFT_W'(3);
  endfunction
endpackage

// File: rtl/sysclk_div_reg.sv
module sysclk_div_reg
  import sysclk_div_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic               sleep_i,
  output logic [REG_W-1:0]   rd_data_o,
  output logic [SHIFT_W-1:0] main_arm_o,
  output logic [SHIFT_W-1:0] sub_arm_o
);
  logic [REG_W-1:0]   reg_q;
  logic [SHIFT_W-1:0] main_arm_q, sub_arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (wr_en_i) begin
      reg_q <= wr_data_i;
    end
  end

  // the sleep strobe samples the register before any same-cycle write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_arm_q <= MAIN_RST_SHIFT;
      sub_arm_q  <= SUB_RST_SHIFT;
    end else if (sleep_i) begin
      main_arm_q <= act_shift(reg_q[ACT_LSB +: ACT_W]);
      sub_arm_q  <= sub_shift(reg_q[0 +: SUB_W]);
    end
  end

  assign rd_data_o  = reg_q;
  assign main_arm_o = main_arm_q;
  assign sub_arm_o  = sub_arm_q;
endmodule

// File: rtl/sysclk_div_presc.sv
module sysclk_div_presc #(
  parameter int                 SHIFT_W   = 3,
  parameter int                 CNT_W     = 6,
  parameter logic [SHIFT_W-1:0] RST_SHIFT = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [SHIFT_W-1:0] arm_shift_i,
  output logic               pulse_o,
  output logic [SHIFT_W-1:0] cur_shift_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [SHIFT_W-1:0] cur_q;
  logic [CNT_W-1:0]   last_cnt;
  logic               wrap;

  assign last_cnt = ~({CNT_W{1'b1}} << cur_q);
  assign wrap     = tick_i && (cnt_q == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cur_q <= RST_SHIFT;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q <= '0;
        cur_q <= arm_shift_i;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign pulse_o     = wrap;
  assign cur_shift_o = cur_q;
endmodule

// File: rtl/sysclk_div_sel.sv
module sysclk_div_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_mode_i,
  input  logic main_pulse_i,
  input  logic sub_pulse_i,
  output logic sel_o,
  output logic clk_en_o
);
  logic sel_q, en_q, cur_pulse;

  assign cur_pulse = sel_q ? sub_pulse_i : main_pulse_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      en_q <= cur_pulse;
      if (cur_pulse) sel_q <= sub_mode_i;
    end
  end

  assign sel_o    = sel_q;
  assign clk_en_o = en_q;
endmodule

// File: rtl/sysclk_div_ctl.sv
module sysclk_div_ctl
  import sysclk_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  reg_rd_data,
  input  logic              main_tick,
  input  logic              watch_tick,
  input  logic              sub_mode_i,
  input  logic              sleep_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              clk_en_o
);
  localparam int NPATH = 2;

  logic [SHIFT_W-1:0] arm_shift [NPATH];
  logic [SHIFT_W-1:0] cur_shift [NPATH];
  logic [NPATH-1:0]   path_tick, path_pulse;
  logic               sel_q;
  logic               main_pulse, sub_pulse;
  logic [SHIFT_W-1:0] main_cur, sub_cur;

  sysclk_div_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (reg_wr_en),
    .wr_data_i (reg_wr_data),
    .sleep_i   (sleep_i),
    .rd_data_o (reg_rd_data),
    .main_arm_o(arm_shift[0]),
    .sub_arm_o (arm_shift[1])
  );

  assign path_tick = {watch_tick, main_tick};

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    localparam logic [SHIFT_W-1:0] RSTV = (p == 0) ? MAIN_RST_SHIFT : SUB_RST_SHIFT;
    sysclk_div_presc #(
      .SHIFT_W  (SHIFT_W),
      .CNT_W    (CNT_W),
      .RST_SHIFT(RSTV)
    ) u_presc (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (path_tick[p]),
      .arm_shift_i(arm_shift[p]),
      .pulse_o    (path_pulse[p]),
      .cur_shift_o(cur_shift[p])
    );
  end

  assign main_pulse = path_pulse[0];
  assign sub_pulse  = path_pulse[1];
  assign main_cur   = cur_shift[0];
  assign sub_cur    = cur_shift[1];

  sysclk_div_sel u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .sub_mode_i  (sub_mode_i),
    .main_pulse_i(main_pulse),
    .sub_pulse_i (sub_pulse),
    .sel_o       (sel_q),
    .clk_en_o    (clk_en_o)
  );

  assign flags_o = reg_rd_data[FLAG_LSB +: FLAG_W];
endmodule

// File: rtl/sysclk_div_chk.sv
module sysclk_div_chk
  import sysclk_div_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr_en,
  input logic [REG_W-1:0]   reg_wr_data,
  input logic [REG_W-1:0]   reg_rd_data,
  input logic               main_tick,
  input logic               watch_tick,
  input logic               clk_en_o,
  input logic               main_pulse,
  input logic               sub_pulse,
  input logic [SHIFT_W-1:0] main_cur,
  input logic [SHIFT_W-1:0] sub_cur,
  input logic               sel_q
);
  // R2
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_rd_data == $past(reg_wr_data));

  // R5
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(reg_rd_data));

  // R6
  main_ratio_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(main_cur) |-> $past(main_pulse));

  // R6
  sub_ratio_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sub_cur) |-> $past(sub_pulse));

  // R7
  mode_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(sel_q ? sub_pulse : main_pulse));

  // R8
  pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_o |-> $past(main_tick || watch_tick));
endmodule

bind sysclk_div_ctl sysclk_div_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_en  (reg_wr_en),
  .reg_wr_data(reg_wr_data),
  .reg_rd_data(reg_rd_data),
  .main_tick  (main_tick),
  .watch_tick (watch_tick),
  .clk_en_o   (clk_en_o),
  .main_pulse (main_pulse),
  .sub_pulse  (sub_pulse),
  .main_cur   (main_cur),
  .sub_cur    (sub_cur),
  .sel_q      (sel_q)
);

// File: tb/sysclk_div_ctl_tb.sv
module sysclk_div_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic       main_tick = 1'b1;
  logic       watch_tick = 1'b1;
  logic       sub_mode_i = 1'b0;
  logic       sleep_i = 1'b0;
  logic [2:0] flags_o;
  logic       clk_en_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sysclk_div_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .main_tick(main_tick), .watch_tick(watch_tick),
    .sub_mode_i(sub_mode_i), .sleep_i(sleep_i), .flags_o(flags_o), .clk_en_o(clk_en_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic sleep_pulse();
    sleep_i = 1'b1;
    @(negedge clk);
    sleep_i = 1'b0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!clk_en_o);
  endtask

  task automatic gap(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!clk_en_o);
  endtask

  task automatic settled_gap(output int g);
    int skip;
    wait_pulse();
    gap(skip);
    gap(g);
  endtask

  task automatic t_reset();
    int g;
    chk(reg_rd_data == 8'h00, "R1", "reset read", reg_rd_data, 0);
    chk(flags_o == 3'b000, "R1", "reset flags", flags_o, 0);
    settled_gap(g);
    chk(g == 1, "R1", "reset main ratio", g, 1);
  endtask

  task automatic t_regrw();
    wr(8'hA5);
    chk(reg_rd_data == 8'hA5, "R2", "readback", reg_rd_data, 8'hA5);
    chk(flags_o == 3'b101, "R2", "flags", flags_o, 5);
    wr(8'h5A);
    chk(reg_rd_data == 8'h5A, "R2", "readback 2", reg_rd_data, 8'h5A);
    chk(flags_o == 3'b010, "R2", "flags 2", flags_o, 2);
  endtask

  task automatic t_active_enc();
    int g;
    int exp_r [6] = '{1, 1, 8, 16, 32, 64};
    logic [2:0] code [6] = '{3'b000, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111};
    for (int i = 0; i < 6; i++) begin
      wr({3'b000, code[i], 2'b00});
      sleep_pulse();
      settled_gap(g);
      chk(g == exp_r[i], "R3", $sformatf("active code %0d", code[i]), g, exp_r[i]);
    end
  endtask

  task automatic t_no_sleep();
    int g;
    wr(8'h10);
    settled_gap(g);
    chk(g == 64, "R5", "rate after write only", g, 64);
    chk(reg_rd_data == 8'h10, "R5", "read new value", reg_rd_data, 8'h10);
  endtask

  task automatic t_boundary();
    int g, t0;
    sleep_pulse();
    settled_gap(g);
    chk(g == 8, "R6", "ratio /8 armed", g, 8);
    t0 = cyc;
    @(negedge clk);
    chk(clk_en_o == 1'b0, "R8", "single-cycle pulse", clk_en_o, 0);
    @(negedge clk);
    wr(8'h1C);
    sleep_pulse();
    wait_pulse();
    chk(cyc - t0 == 8, "R6", "running period kept", cyc - t0, 8);
    gap(g);
    chk(g == 64, "R6", "new period", g, 64);
  endtask

  task automatic t_mode();
    int g, t0;
    wait_pulse();
    t0 = cyc;
    repeat (3) @(negedge clk);
    sub_mode_i = 1'b1;
    wait_pulse();
    chk(cyc - t0 == 64, "R7", "switch waits for main boundary", cyc - t0, 64);
    gap(g);
    gap(g);
    chk(g == 8, "R7", "watch path /8 in use", g, 8);
  endtask

  task automatic t_sub_enc();
    int g;
    int exp_r [4] = '{8, 4, 2, 2};
    for (int i = 0; i < 4; i++) begin
      wr({3'b000, 3'b111, 2'(i)});
      sleep_pulse();
      settled_gap(g);
      chk(g == exp_r[i], "R4", $sformatf("sub code %0d", i), g, exp_r[i]);
    end
  endtask

  task automatic t_same_cycle();
    int g;
    sub_mode_i = 1'b0;
    wait_pulse();
    wait_pulse();
    wr(8'h14);
    sleep_pulse();
    settled_gap(g);
    chk(g == 16, "R9", "setup /16", g, 16);
    reg_wr_en = 1'b1; reg_wr_data = 8'h1C; sleep_i = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; sleep_i = 1'b0;
    chk(reg_rd_data == 8'h1C, "R9", "write landed", reg_rd_data, 8'h1C);
    settled_gap(g);
    chk(g == 16, "R9", "sleep armed old value", g, 16);
  endtask

  task automatic t_tick_gate();
    int g, seen;
    wr(8'h00);
    sleep_pulse();
    settled_gap(g);
    chk(g == 1, "R8", "undivided", g, 1);
    main_tick = 1'b0;
    @(negedge clk);
    seen = 0;
    repeat (20) begin @(negedge clk); if (clk_en_o) seen++; end
    chk(seen == 0, "R8", "no tick no pulse", seen, 0);
    main_tick = 1'b1;
    settled_gap(g);
    chk(g == 1, "R8", "ticks resume", g, 1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regrw();
    t_active_enc();
    t_no_sleep();
    t_boundary();
    t_mode();
    t_sub_enc();
    t_same_cycle();
    t_tick_gate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule